// File: doc/BRIEF.md
# Cascadable Up/Down Decade-Binary Counter

A synchronous programmable counter whose width and counting base are set by parameters. With the base parameter at decade the count runs through 0 to 9; at binary it runs through the full range of the word. Each rising clock edge applies exactly one operation, taken in fixed priority: synchronous clear, then parallel load, then one step up or down. A separate active-low clear resets the count straight away, with no clock edge, and overrides all other inputs.

Two active-low enables must both be low for the counter to step. Enable T is also fed forward into a combinational terminal-count flag, the ripple carry. Its terminal value depends on the direction: the top value when counting up and zero when counting down. A second carry output is this flag gated by the low phase of the clock and by enable P. It therefore pulses only once the clock has gone low. To chain stages, the ripple carry of the lower digit drives enable T of the next digit. The count reaches the outside through a bus that an active-low output enable can float. The counter keeps running while the bus floats.

Top module: `updown_counter`

## Requirements
- R1: While aclr_n is low the count is 0 at once, with no clock edge needed, whatever the other inputs are.
- R2: With aclr_n high and sclr_n low, the count becomes 0 at the next rising edge, even if load_n is low or both enables are low.
- R3: With both clears high and load_n low, the next rising edge loads din, with din[0] as the least significant bit. The load happens whatever the enables are.
- R4: With clears and load_n high, the count steps only if enp_n and ent_n are both low. If either enable is high, the count holds.
- R5: When stepping, up=1 adds one and up=0 subtracts one. In decade mode (DECADE=1) the count wraps 9→0 and 0→9. In binary mode (DECADE=0) it wraps at the ends of the word (15→0 and 0→15 at width 4).
- R6: rco_n is low exactly when ent_n is low and the count is at its terminal value. That value is the top value (9 decade, 15 binary) for up=1 and 0 for up=0. rco_n follows the inputs and the state without a clock edge.
- R7: cco_n is low exactly when clk is low, rco_n is low and enp_n is low. Otherwise it is high.
- R8: With oe_n high the q bus is undriven (high impedance). Stepping, loading and clearing still go on, and the advanced value shows on q once oe_n returns low.
- R9: In decade mode a loaded value above 9 steps to 0 going up and to the value minus one going down. It is never terminal for up=1.
- R10: Two decade stages, with the lower stage's rco_n on the upper stage's ent_n and enp_n shared, count together as a two-digit decimal value 00..99 in both directions. Both wrap at the ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous operations on its rising edge |
| aclr_n | input | 1 | Active-low clear, acts without a clock edge |
| sclr_n | input | 1 | Active-low clear taken at the next rising edge |
| load_n | input | 1 | Active-low parallel load of din |
| din | input | WIDTH | Parallel load value, bit 0 least significant |
| enp_n | input | 1 | Active-low count enable, not fed to the ripple carry |
| ent_n | input | 1 | Active-low count enable, also qualifies the ripple carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| oe_n | input | 1 | Active-low enable for the q bus |
| q | output | WIDTH | Count value on a bus that can float |
| rco_n | output | 1 | Active-low terminal-count flag (combinational) |
| cco_n | output | 1 | Active-low carry, pulses only during the clock low phase |

## Verification
A decade and a binary instance share their inputs. Every value of the 4-bit word is loaded into both, then stepped once up and once down. This separates the two wrap rules and the recovery from values above 9, and it places the terminal flag in each direction.

On every loaded value, the two carry outputs are sampled with each enable raised in turn. This shows that enable T gates the ripple carry, while enable P gates only the clocked carry and only in the clock low phase. Priority is checked by stacking clear, load and enables on one edge.

A two-stage chain is run a full hundred steps up and a full hundred steps down, covering every digit roll-over in both directions. The chain is also cleared in mid-count, both with and without a clock edge, and is loaded. Finally it is held at a terminal digit with enable T high, to confirm that neither carry fires.

// File: rtl/updown_ctr_pkg.sv
package updown_ctr_pkg;

    // Operation chosen for the coming rising edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_COUNT = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/updown_ctr_decode.sv
module updown_ctr_decode
    import updown_ctr_pkg::*;
(
    input  logic    sclr_n,
    input  logic    load_n,
    input  logic    enp_n,
    input  logic    ent_n,
    output ctr_op_e op
);

    // Fixed priority: synchronous clear, then load, then step.
    always_comb begin
        if (!sclr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (!enp_n && !ent_n) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/updown_ctr_step.sv
module updown_ctr_step #(
    parameter int WIDTH  = 4,
    parameter int DECADE = 1
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             up,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] LAST = (DECADE != 0) ? WIDTH'(9) : {WIDTH{1'b1}};

    logic [WIDTH-1:0] inc_val;
    logic [WIDTH-1:0] dec_val;

    generate
        if (DECADE != 0) begin : g_decade
            // Anything at or above the top value returns to zero, so an
            // out-of-range load cannot trap the counter.
            assign inc_val = (cnt >= LAST) ? '0 : cnt + ONE;
            assign dec_val = (cnt == '0) ? LAST : cnt - ONE;
        end else begin : g_binary
            // Natural modulo-2^WIDTH wrap in both directions.
            assign inc_val = cnt + ONE;
            assign dec_val = cnt - ONE;
        end
    endgenerate

    assign nxt = up ? inc_val : dec_val;

endmodule

// File: rtl/updown_ctr_carry.sv
module updown_ctr_carry #(
    parameter int WIDTH  = 4,
    parameter int DECADE = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] cnt,
    input  logic             up,
    input  logic             enp_n,
    input  logic             ent_n,
    output logic             rco_n,
    output logic             cco_n
);

    localparam logic [WIDTH-1:0] LAST = (DECADE != 0) ? WIDTH'(9) : {WIDTH{1'b1}};

    logic at_term;

    // Terminal value depends on direction.
    assign at_term = up ? (cnt == LAST) : (cnt == '0);

    // Enable T is fed forward so a chain settles without waiting a clock.
    assign rco_n = ~(at_term & ~ent_n);

    // Clocked carry: only during the low phase, after the count has settled.
    assign cco_n = ~(~clk & ~rco_n & ~enp_n);

endmodule

// File: rtl/updown_counter.sv
module updown_counter
    import updown_ctr_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int DECADE = 1
) (
    input  logic             clk,
    input  logic             aclr_n,
    input  logic             sclr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             enp_n,
    input  logic             ent_n,
    input  logic             up,
    input  logic             oe_n,
    output wire  [WIDTH-1:0] q,
    output logic             rco_n,
    output logic             cco_n
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ctr_state_t;

    ctr_state_t       state_d;
    ctr_state_t       state_q;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] step_nxt;
    ctr_op_e          op;

    assign cnt_q = state_q.cnt;

    updown_ctr_decode i_decode (
        .sclr_n (sclr_n),
        .load_n (load_n),
        .enp_n  (enp_n),
        .ent_n  (ent_n),
        .op     (op)
    );

    updown_ctr_step #(
        .WIDTH  (WIDTH),
        .DECADE (DECADE)
    ) i_step (
        .cnt (cnt_q),
        .up  (up),
        .nxt (step_nxt)
    );

    updown_ctr_carry #(
        .WIDTH  (WIDTH),
        .DECADE (DECADE)
    ) i_carry (
        .clk   (clk),
        .cnt   (cnt_q),
        .up    (up),
        .enp_n (enp_n),
        .ent_n (ent_n),
        .rco_n (rco_n),
        .cco_n (cco_n)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.cnt = '0;
            OP_LOAD:  state_d.cnt = din;
            OP_COUNT: state_d.cnt = step_nxt;
            default:  state_d     = state_q;
        endcase
    end

    // The asynchronous clear overrides every synchronous operation.
    always_ff @(posedge clk or negedge aclr_n) begin
        if (!aclr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // The output enable touches only the bus, never the state.
    assign q = oe_n ? {WIDTH{1'bz}} : cnt_q;

endmodule

// File: rtl/updown_ctr_chk.sv
module updown_ctr_chk #(
    parameter int WIDTH  = 4,
    parameter int DECADE = 1
) (
    input logic             clk,
    input logic             aclr_n,
    input logic             sclr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             enp_n,
    input logic             ent_n,
    input logic             oe_n,
    input logic             rco_n,
    input logic             cco_n,
    input logic [WIDTH-1:0] cnt_q
);

    a_r2_sync_clear: assert property (@(posedge clk) disable iff (!aclr_n)
        !sclr_n |=> (cnt_q == '0));

    a_r3_load_value: assert property (@(posedge clk) disable iff (!aclr_n)
        (sclr_n && !load_n) |=> (cnt_q == $past(din)));

    a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (!aclr_n)
        (sclr_n && load_n && (enp_n || ent_n)) |=> $stable(cnt_q));

    a_r6_rco_needs_ent: assert property (@(posedge clk) disable iff (!aclr_n)
        ent_n |-> rco_n);

    a_r7_cco_needs_carry: assert property (@(posedge clk) disable iff (!aclr_n)
        !cco_n |-> (!rco_n && !enp_n));

    a_r8_counts_while_floating: assert property (@(posedge clk) disable iff (!aclr_n)
        (oe_n && sclr_n && load_n && !enp_n && !ent_n) |=> (cnt_q != $past(cnt_q)));

    a_r5_decade_stays_in_range: assert property (@(posedge clk) disable iff (!aclr_n)
        ((DECADE != 0) && sclr_n && load_n && !enp_n && !ent_n && (cnt_q <= WIDTH'(9)))
        |=> (cnt_q <= WIDTH'(9)));

endmodule

bind updown_counter updown_ctr_chk #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
) i_chk (
    .clk    (clk),
    .aclr_n (aclr_n),
    .sclr_n (sclr_n),
    .load_n (load_n),
    .din    (din),
    .enp_n  (enp_n),
    .ent_n  (ent_n),
    .oe_n   (oe_n),
    .rco_n  (rco_n),
    .cco_n  (cco_n),
    .cnt_q  (cnt_q)
);

// File: tb/test_updown_counter.sv
`timescale 1ns/1ps
module test_updown_counter;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // Shared stimulus for the decade and binary instances.
    logic       aclr_n, sclr_n, load_n, enp_n, ent_n, up, oe_n;
    logic [3:0] din;
    wire  [3:0] q_dec, q_bin;
    logic       rco_dec, cco_dec, rco_bin, cco_bin;

    // Cascade stimulus.
    logic       c_aclr_n, c_sclr_n, c_load_n, c_enp_n, c_ent_n, c_up;
    logic [3:0] c_din_lo, c_din_hi;
    wire  [3:0] q_lo, q_hi;
    logic       rco_lo, cco_lo, rco_hi, cco_hi;

    // A floating bus reads as all ones.
    for (genvar i = 0; i < 4; i++) begin : g_pull
        pullup pu_dec (q_dec[i]);
        pullup pu_bin (q_bin[i]);
    end

    updown_counter #(.WIDTH(4), .DECADE(1)) i_updown_counter (
        .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n), .din(din),
        .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n),
        .q(q_dec), .rco_n(rco_dec), .cco_n(cco_dec));

    updown_counter #(.WIDTH(4), .DECADE(0)) i_bin (
        .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n), .din(din),
        .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n),
        .q(q_bin), .rco_n(rco_bin), .cco_n(cco_bin));

    updown_counter #(.WIDTH(4), .DECADE(1)) i_stage_lo (
        .clk(clk), .aclr_n(c_aclr_n), .sclr_n(c_sclr_n), .load_n(c_load_n), .din(c_din_lo),
        .enp_n(c_enp_n), .ent_n(c_ent_n), .up(c_up), .oe_n(1'b0),
        .q(q_lo), .rco_n(rco_lo), .cco_n(cco_lo));

    updown_counter #(.WIDTH(4), .DECADE(1)) i_stage_hi (
        .clk(clk), .aclr_n(c_aclr_n), .sclr_n(c_sclr_n), .load_n(c_load_n), .din(c_din_hi),
        .enp_n(c_enp_n), .ent_n(rco_lo), .up(c_up), .oe_n(1'b0),
        .q(q_hi), .rco_n(rco_hi), .cco_n(cco_hi));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Ends 5 ns after a rising edge, with the clock high.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    function automatic int dec_next(int v, bit dir);
        if (dir) return (v >= 9) ? 0 : v + 1;
        return (v == 0) ? 9 : v - 1;
    endfunction

    function automatic int bin_next(int v, bit dir);
        return dir ? (v + 1) % 16 : (v + 15) % 16;
    endfunction

    function automatic logic [7:0] two_digit();
        return 8'(int'(q_hi) * 10 + int'(q_lo));
    endfunction

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog R10 act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        aclr_n = 0; sclr_n = 1; load_n = 1; enp_n = 1; ent_n = 1; up = 1; oe_n = 0; din = 0;
        c_aclr_n = 0; c_sclr_n = 1; c_load_n = 1; c_enp_n = 1; c_ent_n = 0; c_up = 1;
        c_din_lo = 0; c_din_hi = 0;
        tick(); tick();
        chk("R1 reset dec", 8'(q_dec), 8'd0);
        chk("R1 reset bin", 8'(q_bin), 8'd0);
        chk("R6 reset rco", 8'(rco_dec), 8'd1);
        aclr_n = 1; c_aclr_n = 1;
        tick();

        // Every value, both directions, both bases.
        for (int v = 0; v < 16; v++) begin
            for (int d = 0; d < 2; d++) begin
                bit dir = (d == 0);
                up = dir; load_n = 0; din = 4'(v); enp_n = 1; ent_n = 1;
                tick();
                chk("R3 load dec", 8'(q_dec), 8'(v));
                chk("R3 load bin", 8'(q_bin), 8'(v));
                load_n = 1;
                #1;
                chk("R6 ent high dec", 8'(rco_dec), 8'd1);
                chk("R6 ent high bin", 8'(rco_bin), 8'd1);
                ent_n = 0;
                #1;
                chk("R6/R9 rco dec", 8'(rco_dec), 8'(!(dir ? (v == 9) : (v == 0))));
                chk("R6 rco bin", 8'(rco_bin), 8'(!(dir ? (v == 15) : (v == 0))));
                @(negedge clk); #2;
                chk("R7 cco enp high", 8'(cco_dec), 8'd1);
                enp_n = 0;
                #1;
                chk("R7 cco dec", 8'(cco_dec), 8'(!(dir ? (v == 9) : (v == 0))));
                chk("R7 cco bin", 8'(cco_bin), 8'(!(dir ? (v == 15) : (v == 0))));
                tick();
                chk("R7 cco clk high", 8'(cco_dec & cco_bin), 8'd1);
                chk("R5/R9 step dec", 8'(q_dec), 8'(dec_next(v, dir)));
                chk("R5 step bin", 8'(q_bin), 8'(bin_next(v, dir)));
                enp_n = 1;
                tick();
                chk("R4 hold enp", 8'(q_dec), 8'(dec_next(v, dir)));
                enp_n = 0; ent_n = 1;
                tick();
                chk("R4 hold ent", 8'(q_bin), 8'(bin_next(v, dir)));
            end
        end

        // Priority stacking.
        up = 1; enp_n = 0; ent_n = 0; load_n = 0; din = 4'd5; sclr_n = 0;
        tick();
        chk("R2 sclr over load", 8'(q_dec), 8'd0);
        sclr_n = 1;
        tick();
        chk("R3 load over count", 8'(q_dec), 8'd5);
        load_n = 1;
        tick();
        chk("R4 count", 8'(q_dec), 8'd6);
        sclr_n = 0;
        tick();
        chk("R2 sclr over count", 8'(q_bin), 8'd0);
        sclr_n = 1;

        // Output enable.
        load_n = 0; din = 4'd3;
        tick();
        load_n = 1; oe_n = 1;
        tick(); tick();
        chk("R8 floating", 8'(q_dec), 8'h0f);
        oe_n = 0;
        #1;
        chk("R8 counted while floating", 8'(q_dec), 8'd5);

        // Async clear without an edge.
        aclr_n = 0;
        #1;
        chk("R1 async immediate", 8'(q_dec), 8'd0);
        chk("R1 async bin", 8'(q_bin), 8'd0);
        tick();
        aclr_n = 1; enp_n = 1;
        tick();

        // Cascade: 100 up, 100 down.
        c_enp_n = 0; c_ent_n = 0; c_up = 1;
        for (int i = 1; i <= 100; i++) begin
            tick();
            chk("R10 cascade up", two_digit(), 8'(i % 100));
        end
        c_up = 0;
        for (int i = 1; i <= 100; i++) begin
            tick();
            chk("R10 cascade down", two_digit(), 8'((100 - i) % 100));
        end

        // Load, count, async clear mid count.
        c_up = 1; c_load_n = 0; c_din_lo = 4'd7; c_din_hi = 4'd3;
        tick();
        chk("R3 cascade load", two_digit(), 8'd37);
        c_load_n = 1;
        tick(); tick(); tick();
        chk("R10 cascade roll", two_digit(), 8'd40);
        c_aclr_n = 0;
        #1;
        chk("R1 cascade async", two_digit(), 8'd0);
        tick();
        c_aclr_n = 1;
        tick();
        chk("R10 after async", two_digit(), 8'd1);

        // Sync clear.
        c_load_n = 0; c_din_lo = 4'd5; c_din_hi = 4'd5;
        tick();
        c_load_n = 1; c_sclr_n = 0;
        tick();
        chk("R2 cascade sclr", two_digit(), 8'd0);
        c_sclr_n = 1;

        // Terminal digit with enable T high: no carry.
        c_enp_n = 1; c_load_n = 0; c_din_lo = 4'd9; c_din_hi = 4'd0;
        tick();
        c_load_n = 1; c_ent_n = 1; c_enp_n = 0;
        #1;
        chk("R6 cascade ent high", 8'(rco_lo), 8'd1);
        @(negedge clk); #2;
        chk("R7 cascade ent high", 8'(cco_lo), 8'd1);
        tick();
        chk("R4 cascade hold", two_digit(), 8'd9);
        c_ent_n = 0;
        #1;
        chk("R6 cascade terminal", 8'(rco_lo), 8'd0);
        @(negedge clk); #2;
        chk("R7 cascade pulse", 8'(cco_lo), 8'd0);
        tick();
        chk("R10 cascade carry", two_digit(), 8'd10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule